// File: doc/BRIEF.md
# Step-Adjustable PWM Generator

This block produces a pulse-width-modulated signal with a fixed period and a duty cycle that two single-bit requests move up or down one level at a time. A single free-running clock feeds two clock-enable dividers. The fast enable advances a 4-bit reference counter, which sets the PWM period. The slow enable paces how often the duty register may step. The output is high while the reference count is below the duty value. A complementary output is driven alongside it, so a two-color indicator can blend between its colors.

The request inputs may be asynchronous, such as push buttons. Each one passes through a two-flop synchronizer before the slow enable samples it. Holding a request steps the duty once per slow enable. The duty saturates at both ends and never wraps. All logic runs on the one clock and uses enables instead of derived clocks.

Top module: `pwm_step_top`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted on a clock edge, the duty value is loaded with 8 and the reference counter and both dividers are cleared. `pwm_o` reads 0 and `pwm_n_o` reads 1 from the edge after reset is first sampled.
- R2: The reference counter advances by one, modulo 16, once every FAST_DIV clock cycles and holds otherwise. The PWM period is therefore 16*FAST_DIV cycles.
- R3: `pwm_o` is high while the reference count is strictly less than the duty value. Over any full period it is high for exactly duty*FAST_DIV cycles, so a duty of 0 gives a constant low.
- R4: On a slow enable with the synchronized up request high, the duty value rises by one.
- R5: On a slow enable with the synchronized down request high and the up request low, the duty value falls by one.
- R6: On a slow enable with both requests high, the duty value rises by one.
- R7: The duty value saturates at 15: an up step at 15 leaves it at 15.
- R8: The duty value saturates at 0: a down step at 0 leaves it at 0.
- R9: `pwm_n_o` is always the logical inverse of `pwm_o`.
- R10: The duty value changes only on a slow enable, which occurs once every SLOW_DIV clock cycles. A request held high for exactly N*SLOW_DIV consecutive cycles therefore produces exactly N steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Request to raise the duty (asynchronous) |
| dn_req | input | 1 | Request to lower the duty (asynchronous) |
| pwm_o | output | 1 | Pulse-width-modulated output |
| pwm_n_o | output | 1 | Inverse of `pwm_o` |

## Verification
The bench holds a request for an exact multiple of the slow enable period and confirms the exact number of steps. A design that sampled the request on every clock, or lost a tick inside the synchronizer, would overshoot or undershoot the count. The bench drives the duty past both ends, where a design that wrapped would jump from 15 to 0 or from 0 to 15, and a duty of 0 must give a flat low output rather than a one-count sliver. It drives both requests together to expose a design that gives down priority. It also measures high time and period over whole periods to catch an off-by-one compare (less-or-equal instead of less-than) or a counter that advances at the wrong rate.

// File: rtl/pwm_step_pkg.sv
package pwm_step_pkg;
    localparam int unsigned DUTY_W     = 4;
    localparam int unsigned DUTY_MAX   = (1 << DUTY_W) - 1;
    localparam int unsigned DUTY_RESET = 1 << (DUTY_W - 1);

    typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/step_sync.sv
module step_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic meta;
        logic held;
    } stage_t;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        stage_t st_d, st_q;

        always_comb begin
            st_d      = st_q;
            st_d.meta = async_i[b];
            st_d.held = st_q.meta;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign sync_o[b] = st_q.held;
    end
endmodule

// File: rtl/clk_en_div.sv
module clk_en_div #(
    parameter int unsigned RATIO = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;
    logic at_last;

    always_comb begin
        div_d   = div_q;
        at_last = (div_q.cnt == LAST);
        if (at_last) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign tick_o = at_last;
endmodule

// File: rtl/duty_stepper.sv
module duty_stepper
    import pwm_step_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step_en,
    input  logic  up_i,
    input  logic  dn_i,
    output duty_t duty_o
);
    typedef struct packed {
        duty_t duty;
    } reg_t;

    reg_t r_d, r_q;
    logic at_top, at_bottom;

    always_comb begin
        r_d       = r_q;
        at_top    = (r_q.duty == duty_t'(DUTY_MAX));
        at_bottom = (r_q.duty == '0);
        if (step_en) begin
            if (up_i) begin
                if (!at_top) r_d.duty = r_q.duty + duty_t'(1);
            end else if (dn_i) begin
                if (!at_bottom) r_d.duty = r_q.duty - duty_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.duty <= duty_t'(DUTY_RESET);
        end else begin
            r_q <= r_d;
        end
    end

    assign duty_o = r_q.duty;
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import pwm_step_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv_i,
    input  duty_t duty_i,
    output duty_t ref_o,
    output logic  pwm_o,
    output logic  pwm_n_o
);
    typedef struct packed {
        duty_t refc;
        logic  pwm;
        logic  pwm_n;
    } cmp_t;

    cmp_t c_d, c_q;
    logic below;

    always_comb begin
        c_d   = c_q;
        below = (c_q.refc < duty_i);
        if (adv_i) begin
            c_d.refc = c_q.refc + duty_t'(1);
        end
        c_d.pwm   = below;
        c_d.pwm_n = !below;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.refc  <= '0;
            c_q.pwm   <= 1'b0;
            c_q.pwm_n <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign ref_o   = c_q.refc;
    assign pwm_o   = c_q.pwm;
    assign pwm_n_o = c_q.pwm_n;
endmodule

// File: rtl/pwm_step_top.sv
module pwm_step_top
    import pwm_step_pkg::*;
#(
    parameter int unsigned FAST_DIV = 4,
    parameter int unsigned SLOW_DIV = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic up_req,
    input  logic dn_req,
    output logic pwm_o,
    output logic pwm_n_o
);
    logic [1:0] req_s;
    logic       up_s, dn_s;
    logic       fast_tick, slow_tick;
    duty_t      duty_q, ref_q;

    step_sync #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({dn_req, up_req}),
        .sync_o  (req_s)
    );
    assign up_s = req_s[0];
    assign dn_s = req_s[1];

    clk_en_div #(.RATIO(FAST_DIV)) u_fast_div (
        .clk    (clk),
        .rst    (rst),
        .tick_o (fast_tick)
    );

    clk_en_div #(.RATIO(SLOW_DIV)) u_slow_div (
        .clk    (clk),
        .rst    (rst),
        .tick_o (slow_tick)
    );

    duty_stepper u_duty (
        .clk     (clk),
        .rst     (rst),
        .step_en (slow_tick),
        .up_i    (up_s),
        .dn_i    (dn_s),
        .duty_o  (duty_q)
    );

    pwm_compare u_cmp (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (fast_tick),
        .duty_i  (duty_q),
        .ref_o   (ref_q),
        .pwm_o   (pwm_o),
        .pwm_n_o (pwm_n_o)
    );
endmodule

// File: rtl/pwm_step_chk.sv
module pwm_step_chk
    import pwm_step_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  fast_tick,
    input logic  slow_tick,
    input logic  up_s,
    input logic  dn_s,
    input duty_t duty_q,
    input duty_t ref_q,
    input logic  pwm_o,
    input logic  pwm_n_o
);
    AST_REF_HOLD: assert property (@(posedge clk) disable iff (rst) !fast_tick |=> $stable(ref_q)); // R2
    AST_REF_STEP: assert property (@(posedge clk) disable iff (rst) fast_tick |=> ref_q == duty_t'($past(ref_q) + duty_t'(1))); // R2
    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst) duty_q == '0 |=> !pwm_o); // R3
    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst) slow_tick && up_s && duty_q != duty_t'(DUTY_MAX) |=> duty_q == duty_t'($past(duty_q) + duty_t'(1))); // R4
    AST_DN_STEP: assert property (@(posedge clk) disable iff (rst) slow_tick && !up_s && dn_s && duty_q != '0 |=> duty_q == duty_t'($past(duty_q) - duty_t'(1))); // R5
    AST_UP_WINS: assert property (@(posedge clk) disable iff (rst) slow_tick && up_s && dn_s && duty_q != duty_t'(DUTY_MAX) |=> duty_q > $past(duty_q)); // R6
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst) slow_tick && up_s && duty_q == duty_t'(DUTY_MAX) |=> duty_q == duty_t'(DUTY_MAX)); // R7
    AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (rst) slow_tick && !up_s && dn_s && duty_q == '0 |=> duty_q == '0); // R8
    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst) pwm_n_o == !pwm_o); // R9
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst) !slow_tick |=> $stable(duty_q)); // R10
endmodule

bind pwm_step_top pwm_step_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .up_s      (up_s),
    .dn_s      (dn_s),
    .duty_q    (duty_q),
    .ref_q     (ref_q),
    .pwm_o     (pwm_o),
    .pwm_n_o   (pwm_n_o)
);

// File: tb/pwm_step_top_tb_top.sv
module pwm_step_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FAST       = 2;
    localparam int SLOW       = 40;
    localparam int PERIOD     = 16 * FAST;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up_req = 1'b0;
    logic dn_req = 1'b0;
    logic pwm_o, pwm_n_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    bit mon_busy = 1'b0;
    int model_duty = 8;

    typedef struct {
        int    duty;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_step_top #(.FAST_DIV(FAST), .SLOW_DIV(SLOW)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .up_req  (up_req),
        .dn_req  (dn_req),
        .pwm_o   (pwm_o),
        .pwm_n_o (pwm_n_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Driver: hold requests for n slow periods, update the model, queue the expectation
    task automatic drive_steps(input bit up, input bit dn, input int n, input string tag);
        @(negedge clk);
        up_req = up;
        dn_req = dn;
        repeat (n * SLOW) @(negedge clk);
        up_req = 1'b0;
        dn_req = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (up) begin
                if (model_duty < 15) model_duty++;
            end else if (dn) begin
                if (model_duty > 0) model_duty--;
            end
        end
        exp_q.push_back('{model_duty, tag});
        mon_busy = 1'b1;
        wait (!mon_busy);
    endtask

    // Monitor: settle, then count high cycles over one whole period
    initial begin
        forever begin
            exp_t e;
            int   high;
            bit   comp_ok;
            wait (exp_q.size() > 0);
            e = exp_q.pop_front();
            repeat (4 + PERIOD) @(negedge clk);
            high = 0;
            comp_ok = 1'b1;
            for (int i = 0; i < PERIOD; i++) begin
                @(negedge clk);
                if (pwm_o) high++;
                if (pwm_n_o == pwm_o) comp_ok = 1'b0;
            end
            check(high == e.duty * FAST, e.tag, high, e.duty * FAST);
            check(comp_ok, "R9 complement", int'(comp_ok), 1);
            mon_busy = 1'b0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int t_rise;
        int gap;
        repeat (3) @(negedge clk);
        check(pwm_o == 1'b0, "R1 pwm in reset", int'(pwm_o), 0);
        check(pwm_n_o == 1'b1, "R1 pwm_n in reset", int'(pwm_n_o), 1);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R3: duty 8 after reset gives half of the period high
        exp_q.push_back('{8, "R1 R3 reset duty"});
        mon_busy = 1'b1;
        wait (!mon_busy);

        // R2: spacing between rising edges equals 16*FAST
        @(negedge clk);
        while (!(pwm_o == 1'b0)) @(negedge clk);
        while (!(pwm_o == 1'b1)) @(negedge clk);
        t_rise = 0;
        @(negedge clk);
        while (pwm_o == 1'b1) begin t_rise++; @(negedge clk); end
        while (pwm_o == 1'b0) begin t_rise++; @(negedge clk); end
        gap = t_rise + 1;
        check(gap == PERIOD, "R2 period", gap, PERIOD);

        drive_steps(1'b1, 1'b0, 3, "R4 R10 three up steps");
        drive_steps(1'b0, 1'b1, 2, "R5 R10 two down steps");
        drive_steps(1'b1, 1'b1, 1, "R6 up wins");
        drive_steps(1'b1, 1'b0, 10, "R7 saturate top");
        drive_steps(1'b0, 1'b1, 20, "R8 R3 saturate bottom");
        drive_steps(1'b1, 1'b0, 1, "R3 R4 duty one");
        finish_run();
    end
endmodule